// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This unit computes the program counter that follows a control-flow instruction, together with the number of cycles that instruction costs. The decoder supplies a class code for the instruction and the operands the class needs. These are the current PC, the status byte, a raw signed offset, an absolute target, a 16-bit pointer with its upper extension bits, a bit index with a wanted polarity, a register value, two compare operands, and a flag that marks the instruction after this one as two words long.

Every condition is reduced to one comparison. For branches, a chosen status bit is compared against a wanted level. For skips, a chosen register bit is compared the same way, or two operands are compared for equality. A taken branch moves by a sign-extended 7-bit offset. A relative jump moves by a sign-extended 12-bit offset. A taken skip moves past one or two words, depending on the length of the following instruction. The results are registered, so they appear on the outputs one clock after the inputs are applied.

Top module: `bnpc_unit`

## Requirements
- R1: An active-low asynchronous reset clears `npc_o`, `cycles_o` and `taken_o` to 0 at once. Outside reset, each rising clock edge loads the result for the inputs present at that edge, so a result shows on the outputs one clock after its inputs are applied.
- R2: Class 0 (sequential) gives PC+1, 1 cycle, taken 0. Every other input is ignored.
- R3: Class 1 (relative jump) gives PC + sext(offset[11:0]) + 1, 2 cycles, taken 1.
- R4: Class 2 (absolute jump) gives the target input, 3 cycles, taken 1.
- R5: Class 3 (indirect) gives the zero-extended 16-bit pointer. Class 4 (extended indirect) gives {ext, pointer}. Both cost 2 cycles and give taken 1.
- R6: Class 5 (branch) is taken when status bit `bit_sel_i` equals `want_set_i`. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Same-or-higher tests C with want 0, lower tests C with want 1, signed greater-or-equal tests S with want 0, and signed less-than tests S with want 1. A taken branch gives PC + sext(offset[6:0]) + 1, 2 cycles, taken 1. Offset bits 11:7 are ignored.
- R7: A branch or skip whose condition fails gives PC+1, 1 cycle, taken 0.
- R8: Class 6 (bit skip) has its condition met when `reg_val_i[bit_sel_i]` equals `want_set_i`. The status byte plays no part.
- R9: Class 7 (equality skip) has its condition met when `cmp_a_i` equals `cmp_b_i`.
- R10: A skip whose condition is met gives PC+2 with 2 cycles when `next_two_word_i` is 0, and PC+3 with 3 cycles when it is 1. Taken is 1 in both cases.
- R11: All PC arithmetic wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | PC_W | Address of the current instruction |
| cls_i | input | 3 | Instruction class code |
| sreg_i | input | DATA_W | Status byte |
| offset_i | input | JMP_OFF_W | Raw signed offset |
| target_i | input | PC_W | Absolute jump target |
| ptr_i | input | PTR_W | Pointer used by indirect jumps |
| ext_i | input | PC_W-PTR_W | Upper PC bits for the extended indirect jump |
| bit_sel_i | input | log2(DATA_W) | Bit index for branch and bit-skip tests |
| want_set_i | input | 1 | Wanted level of the tested bit |
| reg_val_i | input | DATA_W | Register value for the bit skip |
| cmp_a_i | input | DATA_W | First equality operand |
| cmp_b_i | input | DATA_W | Second equality operand |
| next_two_word_i | input | 1 | Following instruction is two words long |
| npc_o | output | PC_W | Registered next PC |
| cycles_o | output | 2 | Registered cycle cost |
| taken_o | output | 1 | Registered flow-change indication |

## Verification
The block holds only its output register, so a wrong internal result shows at the ports exactly one clock after the inputs that caused it. A failed condition evaluation shows up as a PC+1 result where a jump was expected, or the reverse, and the cycle count and taken flag go wrong together with it. An adder fault shows up as a wrong target, and the most visible cases are offsets at their extreme values and PCs close to the wrap point. A mixed-up skip length shows up as PC+2 where PC+3 was due, with the cycle count off by one.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  typedef enum logic [2:0] {
    CF_SEQ      = 3'd0,
    CF_RJMP     = 3'd1,
    CF_JMP      = 3'd2,
    CF_IJMP     = 3'd3,
    CF_EIJMP    = 3'd4,
    CF_BRANCH   = 3'd5,
    CF_SKIP_BIT = 3'd6,
    CF_SKIP_EQ  = 3'd7
  } cf_class_e;

  typedef logic [1:0] cyc_t;

  localparam cyc_t CYC_RST = 2'd0;
  localparam cyc_t CYC_1   = 2'd1;
  localparam cyc_t CYC_2   = 2'd2;
  localparam cyc_t CYC_3   = 2'd3;

endpackage

// File: rtl/bnpc_cond.sv
// Evaluates the single-bit condition of branch and skip classes.
module bnpc_cond
  import bnpc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  cf_class_e          cls_i,
  input  logic [DATA_W-1:0]  sreg_i,
  input  logic [IDX_W-1:0]   bit_sel_i,
  input  logic               want_set_i,
  input  logic [DATA_W-1:0]  reg_val_i,
  input  logic [DATA_W-1:0]  cmp_a_i,
  input  logic [DATA_W-1:0]  cmp_b_i,
  output logic               cond_o
);

  logic [DATA_W-1:0] sreg_pick;
  logic [DATA_W-1:0] reg_pick;
  logic              sreg_bit;
  logic              reg_bit;
  logic              operands_eq;

  // one-hot bit pick, one lane per bit position
  for (genvar g = 0; g < DATA_W; g++) begin : g_pick
    assign sreg_pick[g] = (bit_sel_i == IDX_W'(g)) & sreg_i[g];
    assign reg_pick[g]  = (bit_sel_i == IDX_W'(g)) & reg_val_i[g];
  end

  assign sreg_bit    = |sreg_pick;
  assign reg_bit     = |reg_pick;
  assign operands_eq = (cmp_a_i == cmp_b_i);

  always_comb begin
    unique case (cls_i)
      CF_BRANCH:   cond_o = (sreg_bit == want_set_i);
      CF_SKIP_BIT: cond_o = (reg_bit == want_set_i);
      CF_SKIP_EQ:  cond_o = operands_eq;
      default:     cond_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bnpc_addr.sv
// Candidate next-PC values, all computed in parallel.
module bnpc_addr #(
  parameter int PC_W      = 22,
  parameter int PTR_W     = 16,
  parameter int BR_OFF_W  = 7,
  parameter int JMP_OFF_W = 12,
  localparam int EXT_W    = (PC_W > PTR_W) ? (PC_W - PTR_W) : 1
) (
  input  logic [PC_W-1:0]      pc_i,
  input  logic [JMP_OFF_W-1:0] offset_i,
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [EXT_W-1:0]     ext_i,
  output logic [PC_W-1:0]      seq_o,
  output logic [PC_W-1:0]      rjmp_o,
  output logic [PC_W-1:0]      rbr_o,
  output logic [PC_W-1:0]      skip1_o,
  output logic [PC_W-1:0]      skip2_o,
  output logic [PC_W-1:0]      ind_o,
  output logic [PC_W-1:0]      ind_ext_o
);

  logic [PC_W-1:0] jmp_disp;
  logic [PC_W-1:0] br_disp;

  assign jmp_disp = {{(PC_W-JMP_OFF_W){offset_i[JMP_OFF_W-1]}}, offset_i};
  assign br_disp  = {{(PC_W-BR_OFF_W){offset_i[BR_OFF_W-1]}}, offset_i[BR_OFF_W-1:0]};

  // both relative forms share the PC+1 base
  assign seq_o   = pc_i + PC_W'(1);
  assign rjmp_o  = seq_o + jmp_disp;
  assign rbr_o   = seq_o + br_disp;
  assign skip1_o = pc_i + PC_W'(2);
  assign skip2_o = pc_i + PC_W'(3);

  if (PC_W > PTR_W) begin : g_wide
    assign ind_o     = {{(PC_W-PTR_W){1'b0}}, ptr_i};
    assign ind_ext_o = {ext_i, ptr_i};
  end else begin : g_narrow
    logic ext_unused;
    assign ext_unused = ^ext_i;
    assign ind_o      = ptr_i[PC_W-1:0];
    assign ind_ext_o  = ptr_i[PC_W-1:0] | {{(PC_W-1){1'b0}}, ext_unused & 1'b0};
  end

endmodule

// File: rtl/bnpc_sel.sv
// Chooses the next PC, cycle cost and taken flag for the class.
module bnpc_sel
  import bnpc_pkg::*;
#(
  parameter int PC_W = 22
) (
  input  cf_class_e        cls_i,
  input  logic             cond_i,
  input  logic             next_two_word_i,
  input  logic [PC_W-1:0]  seq_i,
  input  logic [PC_W-1:0]  rjmp_i,
  input  logic [PC_W-1:0]  rbr_i,
  input  logic [PC_W-1:0]  skip1_i,
  input  logic [PC_W-1:0]  skip2_i,
  input  logic [PC_W-1:0]  abs_i,
  input  logic [PC_W-1:0]  ind_i,
  input  logic [PC_W-1:0]  ind_ext_i,
  output logic [PC_W-1:0]  npc_o,
  output cyc_t             cyc_o,
  output logic             taken_o
);

  always_comb begin
    npc_o   = seq_i;
    cyc_o   = CYC_1;
    taken_o = 1'b0;
    unique case (cls_i)
      CF_SEQ: begin
        npc_o   = seq_i;
        cyc_o   = CYC_1;
        taken_o = 1'b0;
      end
      CF_RJMP: begin
        npc_o   = rjmp_i;
        cyc_o   = CYC_2;
        taken_o = 1'b1;
      end
      CF_JMP: begin
        npc_o   = abs_i;
        cyc_o   = CYC_3;
        taken_o = 1'b1;
      end
      CF_IJMP: begin
        npc_o   = ind_i;
        cyc_o   = CYC_2;
        taken_o = 1'b1;
      end
      CF_EIJMP: begin
        npc_o   = ind_ext_i;
        cyc_o   = CYC_2;
        taken_o = 1'b1;
      end
      CF_BRANCH: begin
        if (cond_i) begin
          npc_o   = rbr_i;
          cyc_o   = CYC_2;
          taken_o = 1'b1;
        end
      end
      CF_SKIP_BIT, CF_SKIP_EQ: begin
        if (cond_i) begin
          taken_o = 1'b1;
          if (next_two_word_i) begin
            npc_o = skip2_i;
            cyc_o = CYC_3;
          end else begin
            npc_o = skip1_i;
            cyc_o = CYC_2;
          end
        end
      end
      default: begin
        npc_o   = seq_i;
        cyc_o   = CYC_1;
        taken_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int PC_W      = 22,
  parameter int PTR_W     = 16,
  parameter int DATA_W    = 8,
  parameter int BR_OFF_W  = 7,
  parameter int JMP_OFF_W = 12,
  localparam int EXT_W    = (PC_W > PTR_W) ? (PC_W - PTR_W) : 1,
  localparam int IDX_W    = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      pc_i,
  input  logic [2:0]           cls_i,
  input  logic [DATA_W-1:0]    sreg_i,
  input  logic [JMP_OFF_W-1:0] offset_i,
  input  logic [PC_W-1:0]      target_i,
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [EXT_W-1:0]     ext_i,
  input  logic [IDX_W-1:0]     bit_sel_i,
  input  logic                 want_set_i,
  input  logic [DATA_W-1:0]    reg_val_i,
  input  logic [DATA_W-1:0]    cmp_a_i,
  input  logic [DATA_W-1:0]    cmp_b_i,
  input  logic                 next_two_word_i,
  output logic [PC_W-1:0]      npc_o,
  output logic [1:0]           cycles_o,
  output logic                 taken_o
);

  cf_class_e       cls;
  logic            cond_w;
  logic [PC_W-1:0] seq_w, rjmp_w, rbr_w, skip1_w, skip2_w, ind_w, ind_ext_w;
  logic [PC_W-1:0] npc_d, npc_q;
  cyc_t            cyc_d, cyc_q;
  logic            taken_d, taken_q;

  assign cls = cf_class_e'(cls_i);

  bnpc_cond #(.DATA_W(DATA_W)) u_cond (
    .cls_i      (cls),
    .sreg_i     (sreg_i),
    .bit_sel_i  (bit_sel_i),
    .want_set_i (want_set_i),
    .reg_val_i  (reg_val_i),
    .cmp_a_i    (cmp_a_i),
    .cmp_b_i    (cmp_b_i),
    .cond_o     (cond_w)
  );

  bnpc_addr #(
    .PC_W(PC_W), .PTR_W(PTR_W), .BR_OFF_W(BR_OFF_W), .JMP_OFF_W(JMP_OFF_W)
  ) u_addr (
    .pc_i      (pc_i),
    .offset_i  (offset_i),
    .ptr_i     (ptr_i),
    .ext_i     (ext_i),
    .seq_o     (seq_w),
    .rjmp_o    (rjmp_w),
    .rbr_o     (rbr_w),
    .skip1_o   (skip1_w),
    .skip2_o   (skip2_w),
    .ind_o     (ind_w),
    .ind_ext_o (ind_ext_w)
  );

  bnpc_sel #(.PC_W(PC_W)) u_sel (
    .cls_i           (cls),
    .cond_i          (cond_w),
    .next_two_word_i (next_two_word_i),
    .seq_i           (seq_w),
    .rjmp_i          (rjmp_w),
    .rbr_i           (rbr_w),
    .skip1_i         (skip1_w),
    .skip2_i         (skip2_w),
    .abs_i           (target_i),
    .ind_i           (ind_w),
    .ind_ext_i       (ind_ext_w),
    .npc_o           (npc_d),
    .cyc_o           (cyc_d),
    .taken_o         (taken_d)
  );

  // result register, loaded every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc_q   <= '0;
      cyc_q   <= CYC_RST;
      taken_q <= 1'b0;
    end else begin
      npc_q   <= npc_d;
      cyc_q   <= cyc_d;
      taken_q <= taken_d;
    end
  end

  assign npc_o    = npc_q;
  assign cycles_o = cyc_q;
  assign taken_o  = taken_q;

  assert_jmp_abs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CF_JMP) |=> (npc_o == $past(target_i)) && (cycles_o == CYC_3));

  assert_eijmp_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CF_EIJMP) |=> (npc_o[PC_W-1:PTR_W] == $past(ext_i)));

  assert_branch_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_i == CF_BRANCH) && cond_w) |-> (sreg_i[bit_sel_i] == want_set_i));

  assert_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_i inside {CF_BRANCH, CF_SKIP_BIT, CF_SKIP_EQ}) && !cond_w)
      |=> (npc_o == $past(pc_i) + PC_W'(1)) && (cycles_o == CYC_1) && !taken_o);

  assert_taken_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (cycles_o >= CYC_2));

  assert_skip_eq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_i == CF_SKIP_EQ) && cond_w) |-> (cmp_a_i == cmp_b_i));

  assert_skip_far_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_i inside {CF_SKIP_BIT, CF_SKIP_EQ}) && cond_w && next_two_word_i)
      |=> (cycles_o == CYC_3) && (npc_o == $past(pc_i) + PC_W'(3)));

endmodule

// File: tb/bnpc_unit_bench.sv
module bnpc_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  typedef struct packed {
    logic [2:0]  cls;
    logic [21:0] pc;
    logic [7:0]  sreg;
    logic [11:0] off;
    logic [21:0] tgt;
    logic [15:0] ptr;
    logic [5:0]  ext;
    logic [2:0]  bsel;
    logic        pol;
    logic [7:0]  rv;
    logic [7:0]  ca;
    logic [7:0]  cb;
    logic        two;
    logic [21:0] epc;
    logic [1:0]  ecyc;
    logic        etk;
    logic [3:0]  req;
  } vec_t;

  // cls pc sreg off tgt ptr ext bsel pol rv ca cb two | epc ecyc etk req
  localparam vec_t VECS [NV] = '{
    '{3'd0, 22'h000100, 8'hFF, 12'h010, 22'h2ABCDE, 16'hBEEF, 6'h15, 3'd0, 1'b1, 8'hFF, 8'h5A, 8'h5A, 1'b1, 22'h000101, 2'd1, 1'b0, 4'd2},  // R2 noise ignored
    '{3'd1, 22'h000100, 8'h00, 12'h010, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 22'h000111, 2'd2, 1'b1, 4'd3},  // R3 forward
    '{3'd1, 22'h000100, 8'h00, 12'hFFE, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 22'h0000FF, 2'd2, 1'b1, 4'd3},  // R3 backward
    '{3'd1, 22'h000000, 8'h00, 12'h800, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 22'h3FF801, 2'd2, 1'b1, 4'd11}, // R11 wrap low
    '{3'd2, 22'h000100, 8'h00, 12'h000, 22'h2ABCDE, 16'h0000, 6'h00, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 22'h2ABCDE, 2'd3, 1'b1, 4'd4},  // R4
    '{3'd3, 22'h000100, 8'h00, 12'h000, 22'h000000, 16'hBEEF, 6'h15, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 22'h00BEEF, 2'd2, 1'b1, 4'd5},  // R5 plain
    '{3'd4, 22'h000100, 8'h00, 12'h000, 22'h000000, 16'hBEEF, 6'h15, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 22'h15BEEF, 2'd2, 1'b1, 4'd5},  // R5 extended
    '{3'd5, 22'h000200, 8'h01, 12'h005, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 22'h000206, 2'd2, 1'b1, 4'd6},  // R6 lower taken
    '{3'd5, 22'h000200, 8'h00, 12'h005, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 22'h000201, 2'd1, 1'b0, 4'd7},  // R7 lower not taken
    '{3'd5, 22'h000200, 8'h00, 12'hF40, 22'h000000, 16'h0000, 6'h00, 3'd4, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 22'h0001C1, 2'd2, 1'b1, 4'd6},  // R6 ge, high bits ignored
    '{3'd5, 22'h3FFFF0, 8'h10, 12'h03F, 22'h000000, 16'h0000, 6'h00, 3'd4, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 22'h000030, 2'd2, 1'b1, 4'd11}, // R11 wrap high
    '{3'd5, 22'h000300, 8'h7F, 12'h005, 22'h000000, 16'h0000, 6'h00, 3'd7, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 22'h000301, 2'd1, 1'b0, 4'd7},  // R7
    '{3'd5, 22'h000300, 8'hFE, 12'h07F, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 22'h000300, 2'd2, 1'b1, 4'd6},  // R6 same-or-higher, -1
    '{3'd6, 22'h000400, 8'h00, 12'h000, 22'h000000, 16'h0000, 6'h00, 3'd7, 1'b1, 8'h80, 8'h00, 8'h00, 1'b0, 22'h000402, 2'd2, 1'b1, 4'd8},  // R8
    '{3'd6, 22'h000400, 8'h00, 12'h000, 22'h000000, 16'h0000, 6'h00, 3'd7, 1'b1, 8'h80, 8'h00, 8'h00, 1'b1, 22'h000403, 2'd3, 1'b1, 4'd10}, // R10 two words
    '{3'd6, 22'h000400, 8'h00, 12'h000, 22'h000000, 16'h0000, 6'h00, 3'd7, 1'b0, 8'h80, 8'h00, 8'h00, 1'b1, 22'h000401, 2'd1, 1'b0, 4'd10}, // R10 not met
    '{3'd6, 22'h000400, 8'h00, 12'h000, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b0, 8'hFE, 8'h00, 8'h00, 1'b0, 22'h000402, 2'd2, 1'b1, 4'd8},  // R8 clear test
    '{3'd7, 22'h3FFFFE, 8'h00, 12'h000, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b0, 8'h00, 8'h5A, 8'h5A, 1'b1, 22'h000001, 2'd3, 1'b1, 4'd11}, // R11 skip wrap
    '{3'd7, 22'h3FFFFE, 8'h00, 12'h000, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b0, 8'h00, 8'h5A, 8'h5B, 1'b1, 22'h3FFFFF, 2'd1, 1'b0, 4'd9},  // R9 unequal
    '{3'd0, 22'h3FFFFF, 8'h00, 12'h000, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 22'h000000, 2'd1, 1'b0, 4'd11}, // R11 seq wrap
    '{3'd7, 22'h000010, 8'h00, 12'h000, 22'h000000, 16'h0000, 6'h00, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 22'h000012, 2'd2, 1'b1, 4'd9},  // R9 equal
    '{3'd6, 22'h000500, 8'hFF, 12'h000, 22'h000000, 16'h0000, 6'h00, 3'd3, 1'b1, 8'hF7, 8'h00, 8'h00, 1'b0, 22'h000501, 2'd1, 1'b0, 4'd8},  // R8 status unused
    '{3'd5, 22'h000500, 8'hDF, 12'h000, 22'h000000, 16'h0000, 6'h00, 3'd5, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b0, 22'h000501, 2'd1, 1'b0, 4'd6}   // R6 reg unused
  };

  logic        clk;
  logic        rst_n;
  logic [21:0] pc_i;
  logic [2:0]  cls_i;
  logic [7:0]  sreg_i;
  logic [11:0] offset_i;
  logic [21:0] target_i;
  logic [15:0] ptr_i;
  logic [5:0]  ext_i;
  logic [2:0]  bit_sel_i;
  logic        want_set_i;
  logic [7:0]  reg_val_i;
  logic [7:0]  cmp_a_i;
  logic [7:0]  cmp_b_i;
  logic        next_two_word_i;
  logic [21:0] npc_o;
  logic [1:0]  cycles_o;
  logic        taken_o;

  int n_checks = 0;
  int n_fails  = 0;

  bnpc_unit #(
    .PC_W(22), .PTR_W(16), .DATA_W(8), .BR_OFF_W(7), .JMP_OFF_W(12)
  ) u_bnpc_unit (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .cls_i(cls_i), .sreg_i(sreg_i),
    .offset_i(offset_i), .target_i(target_i), .ptr_i(ptr_i), .ext_i(ext_i),
    .bit_sel_i(bit_sel_i), .want_set_i(want_set_i), .reg_val_i(reg_val_i),
    .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .next_two_word_i(next_two_word_i),
    .npc_o(npc_o), .cycles_o(cycles_o), .taken_o(taken_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cls_i = v.cls; pc_i = v.pc; sreg_i = v.sreg; offset_i = v.off;
    target_i = v.tgt; ptr_i = v.ptr; ext_i = v.ext; bit_sel_i = v.bsel;
    want_set_i = v.pol; reg_val_i = v.rv; cmp_a_i = v.ca; cmp_b_i = v.cb;
    next_two_word_i = v.two;
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary_and_end();
  end

  initial begin
    vec_t jv;
    rst_n = 1'b0;
    apply('0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 npc in reset", 32'(npc_o), 32'h0);
    chk("R1 cycles in reset", 32'(cycles_o), 32'h0);
    chk("R1 taken in reset", 32'(taken_o), 32'h0);
    rst_n = 1'b1;

    // R1 latency: output holds until the next rising edge
    jv = VECS[4];
    jv.tgt = 22'h123456;
    apply(jv);
    #1;
    chk("R1 no change before edge", 32'(npc_o), 32'h0);
    @(negedge clk);
    chk("R4 target after edge", 32'(npc_o), 32'h123456);
    chk("R4 cycles", 32'(cycles_o), 32'd3);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d npc", VECS[i].req, i), 32'(npc_o), 32'(VECS[i].epc));
      chk($sformatf("R%0d vec%0d cycles", VECS[i].req, i), 32'(cycles_o), 32'(VECS[i].ecyc));
      chk($sformatf("R%0d vec%0d taken", VECS[i].req, i), 32'(taken_o), 32'(VECS[i].etk));
    end

    // R1: asynchronous clear between edges
    apply(VECS[4]);
    @(negedge clk);
    chk("R4 before async reset", 32'(npc_o), 32'h2ABCDE);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async npc", 32'(npc_o), 32'h0);
    chk("R1 async cycles", 32'(cycles_o), 32'h0);
    chk("R1 async taken", 32'(taken_o), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 resume after reset", 32'(npc_o), 32'h2ABCDE);

    summary_and_end();
  end

endmodule